// File: doc/BRIEF.md
# Descriptor chain walker

This block sits in front of a packet DMA data mover and services up to eight independent channel queues. Each queue is a linked list of 16-byte buffer descriptors kept in an on-chip 8 KB descriptor RAM. The host fills the RAM through a plain word port and then writes the byte address of the first descriptor of a list into the channel's head-pointer register. From then on the walker runs without the host. It loads each descriptor and hands the fragment's buffer address and length to the data mover. It then follows the link word to the next descriptor, and a packet may cover several fragments. Once the data mover acknowledges a fragment, the walker writes a status word back into that descriptor. After the fragment that closes a packet it pulses an interrupt for the channel.

A descriptor occupies four 32-bit words at a 16-byte aligned byte address. Word 0 holds the link, which is the byte address of the next descriptor, with zero meaning end of list. Word 1 holds the buffer base. Word 2 holds the buffer offset in bits 31:16 and the fragment length in bits 15:0. Word 3 holds the flags. Bit 31 marks start of packet, bit 30 marks end of packet, bit 29 is the hardware-ownership flag, bit 28 is the end-of-queue flag, and bits 15:0 carry the packet length. A channel stays busy through any number of packets until it reaches a zero link. A pointer that is not aligned, or that points past the RAM, stops the channel and flags an error for it.

Channels take turns in round-robin order. A channel holds the walker for a whole packet, so the fragments of one packet are never interleaved with those of another channel.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset no channel is active, no channel has an error, and dma_req and irq_valid are low.
- R2: A head write with a nonzero address to an inactive channel sets that channel's ch_active in the next cycle and clears its ch_err.
- R3: For each descriptor the walker presents dma_req with dma_addr = word1 + word2[31:16], dma_len = word2[15:0], dma_sop = word3[31], dma_eop = word3[30] and dma_ch = the channel. It holds all of these stable until dma_ack.
- R4: The descriptors of a channel are requested in link order, starting at the head pointer and following word 0. Each descriptor is requested exactly once.
- R5: After a fragment is acknowledged, word 3 of its descriptor reads back with bit 29 cleared and bit 28 set exactly when word 0 is zero. All other bits are unchanged.
- R6: irq_valid pulses for one cycle, with irq_ch naming the channel, once for each descriptor whose bit 30 is set, and never for any other descriptor.
- R7: A channel keeps consuming packets without host action until it finishes a descriptor whose word 0 is zero. Then its ch_active goes low.
- R8: A head or link pointer whose bits 3:0 are nonzero, or which is 8192 or above, is not fetched. The channel's ch_active goes low and its ch_err goes high. A later accepted head write clears the error.
- R9: A head write to a channel that is active, or a head write with address zero, is ignored. The running list and the channel state are unchanged.
- R10: Once a channel's fragment with bit 31 set is requested, every request up to and including its fragment with bit 30 set comes from that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_wr | input | 1 | Head-pointer write strobe |
| hp_ch | input | 3 | Channel for the head write |
| hp_addr | input | 32 | Byte address of the first descriptor |
| host_we | input | 1 | Host descriptor RAM write enable |
| host_addr | input | 11 | Host RAM word address |
| host_wdata | input | 32 | Host RAM write data |
| host_rdata | output | 32 | Host RAM read data, one cycle after the address |
| dma_req | output | 1 | Fragment transfer request |
| dma_ch | output | 3 | Channel of the request |
| dma_addr | output | 32 | Fragment start address |
| dma_len | output | 16 | Fragment length in bytes |
| dma_sop | output | 1 | Fragment opens a packet |
| dma_eop | output | 1 | Fragment closes a packet |
| dma_ack | input | 1 | Data mover finished the fragment |
| irq_valid | output | 1 | Packet-complete interrupt pulse |
| irq_ch | output | 3 | Channel of the completed packet |
| ch_active | output | 8 | Per-channel busy flags |
| ch_err | output | 8 | Per-channel pointer-error flags |

## Verification
Random rounds place lists of one to six descriptors on a random set of channels. Packet boundaries inside each list are random, and the data mover answers with random delays. This separates per-channel ordering and packet atomicity from the round-robin interleaving between channels. A single-descriptor list exercises the case where the first descriptor is also the last. Directed cases then cover a misaligned head, an out-of-range head, a bad link found in the middle of a list, a zero head, and a second head write while the data mover is stalled. Each of these shows whether a bad or ignored pointer leaves the descriptors and flags untouched.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_CHK, ST_RD, ST_DMA, ST_WB} walk_st_e;

  localparam int FLG_SOP = 31;
  localparam int FLG_EOP = 30;
  localparam int FLG_OWN = 29;
  localparam int FLG_EOQ = 28;

  // descriptor pointer legal: 16-byte aligned and inside the RAM window
  function automatic logic ptr_ok(input logic [31:0] p, input int unsigned lim);
    return (p[3:0] == 4'd0) && (p < lim);
  endfunction

  // fragment start = buffer base plus 16-bit offset field
  function automatic logic [31:0] frag_addr(input logic [31:0] base, input logic [31:0] offlen);
    return base + {16'd0, offlen[31:16]};
  endfunction

  // status written back: hardware releases ownership, marks queue end
  function automatic logic [31:0] status_word(input logic [31:0] flags, input logic last);
    logic [31:0] r;
    r = flags;
    r[FLG_OWN] = 1'b0;
    r[FLG_EOQ] = last;
    return r;
  endfunction
endpackage

// File: rtl/dcw_ram.sv
module dcw_ram #(
  parameter int WORDS = 2048,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [31:0]   b_wdata,
  output logic [31:0]   b_rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/dcw_rr_arb.sv
module dcw_rr_arb #(
  parameter int N = 8,
  localparam int CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic [CW-1:0] grant,
  output logic          any
);
  logic [CW-1:0] last_q;

  always_comb begin
    grant = last_q;
    any   = 1'b0;
    for (int i = 1; i <= N; i++) begin
      int idx;
      idx = (int'(last_q) + i) % N;
      if (!any && req[idx]) begin
        any   = 1'b1;
        grant = CW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= CW'(N - 1);
    else if (take && any) last_q <= grant;
  end
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker #(
  parameter int NUM_CH    = 8,
  parameter int RAM_BYTES = 8192,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int WORDS = RAM_BYTES / 4,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hp_wr,
  input  logic [CH_W-1:0]   hp_ch,
  input  logic [31:0]       hp_addr,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              dma_req,
  output logic [CH_W-1:0]   dma_ch,
  output logic [31:0]       dma_addr,
  output logic [15:0]       dma_len,
  output logic              dma_sop,
  output logic              dma_eop,
  input  logic              dma_ack,
  output logic              irq_valid,
  output logic [CH_W-1:0]   irq_ch,
  output logic [NUM_CH-1:0] ch_active,
  output logic [NUM_CH-1:0] ch_err
);
  import dcw_pkg::*;

  walk_st_e        state;
  logic [CH_W-1:0] cur_ch;
  logic [2:0]      rd_idx;
  logic [31:0]     wd [4];
  logic [31:0]     ptr_q [NUM_CH];
  logic [31:0]     cur_ptr;
  logic [CH_W-1:0] grant;
  logic            any_req;
  logic            b_we;
  logic [AW-1:0]   b_addr;
  logic [31:0]     b_rdata;

  // named internal events
  logic ev_start, ev_fault, ev_pkt_done, ev_last;

  assign cur_ptr     = ptr_q[cur_ch];
  assign ev_start    = hp_wr && !ch_active[hp_ch] && (hp_addr != 32'd0);
  assign ev_fault    = (state == ST_CHK) && !ptr_ok(cur_ptr, RAM_BYTES);
  assign ev_last     = (wd[0] == 32'd0);
  assign ev_pkt_done = (state == ST_WB) && wd[3][FLG_EOP];

  assign b_we   = (state == ST_WB);
  assign b_addr = (state == ST_WB) ? {cur_ptr[AW+1:4], 2'd3}
                                   : {cur_ptr[AW+1:4], rd_idx[1:0]};

  dcw_ram #(.WORDS(WORDS)) u_ram (
    .clk(clk),
    .a_we(host_we), .a_addr(host_addr), .a_wdata(host_wdata), .a_rdata(host_rdata),
    .b_we(b_we), .b_addr(b_addr), .b_wdata(status_word(wd[3], ev_last)), .b_rdata(b_rdata)
  );

  dcw_rr_arb #(.N(NUM_CH)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(ch_active),
    .take(state == ST_IDLE), .grant(grant), .any(any_req)
  );

  assign dma_req  = (state == ST_DMA);
  assign dma_ch   = cur_ch;
  assign dma_addr = frag_addr(wd[1], wd[2]);
  assign dma_len  = wd[2][15:0];
  assign dma_sop  = wd[3][FLG_SOP];
  assign dma_eop  = wd[3][FLG_EOP];

  // walker sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cur_ch <= '0;
      rd_idx <= '0;
      for (int k = 0; k < 4; k++) wd[k] <= '0;
    end else begin
      case (state)
        ST_IDLE: if (any_req) begin
          cur_ch <= grant;
          state  <= ST_CHK;
        end
        ST_CHK: begin
          rd_idx <= '0;
          state  <= ev_fault ? ST_IDLE : ST_RD;
        end
        ST_RD: begin
          if (rd_idx != 3'd0) wd[rd_idx[1:0] - 2'd1] <= b_rdata;
          if (rd_idx == 3'd4) state <= ST_DMA;
          else rd_idx <= rd_idx + 3'd1;
        end
        ST_DMA: if (dma_ack) state <= ST_WB;
        ST_WB: state <= (ev_last || wd[3][FLG_EOP]) ? ST_IDLE : ST_CHK;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // per-channel pointer, busy and error state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_active <= '0;
      ch_err    <= '0;
      for (int i = 0; i < NUM_CH; i++) ptr_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ev_start && hp_ch == CH_W'(i)) begin
          ptr_q[i]     <= hp_addr;
          ch_active[i] <= 1'b1;
          ch_err[i]    <= 1'b0;
        end else if (cur_ch == CH_W'(i)) begin
          if (ev_fault) begin
            ch_active[i] <= 1'b0;
            ch_err[i]    <= 1'b1;
          end else if (state == ST_WB) begin
            if (ev_last) ch_active[i] <= 1'b0;
            else ptr_q[i] <= wd[0];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_ch    <= '0;
    end else begin
      irq_valid <= ev_pkt_done;
      irq_ch    <= cur_ch;
    end
  end
endmodule

// File: rtl/desc_chain_walker_chk.sv
module desc_chain_walker_chk #(
  parameter int N  = 8,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hp_wr,
  input logic [CW-1:0] hp_ch,
  input logic [31:0]   hp_addr,
  input logic          dma_req,
  input logic          dma_ack,
  input logic [CW-1:0] dma_ch,
  input logic [31:0]   dma_addr,
  input logic [15:0]   dma_len,
  input logic          dma_sop,
  input logic          dma_eop,
  input logic          irq_valid,
  input logic [N-1:0]  ch_active,
  input logic [N-1:0]  ch_err,
  input logic          ev_fault,
  input logic          ev_pkt_done
);
  logic          in_pkt;
  logic [CW-1:0] pkt_ch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      pkt_ch <= '0;
    end else if (dma_req && dma_ack) begin
      in_pkt <= !dma_eop;
      pkt_ch <= dma_ch;
    end
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack |=> dma_req && $stable(dma_addr) && $stable(dma_len)
                            && $stable(dma_ch) && $stable(dma_sop) && $stable(dma_eop));

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hp_wr && hp_addr != 32'd0 && !ch_active[hp_ch] |=> ch_active[$past(hp_ch)] && !ch_err[$past(hp_ch)]);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);

  p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pkt_done |=> irq_valid);

  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_err & ch_active) == '0);

  p_fault_nodma_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> !dma_req);

  p_atomic_pkt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && in_pkt |-> dma_ch == pkt_ch);
endmodule

bind desc_chain_walker desc_chain_walker_chk #(.N(NUM_CH), .CW(CH_W)) u_chk (.*);

// File: tb/desc_chain_walker_test.sv
module desc_chain_walker_test;
  localparam int PERIOD = 10;
  localparam int NCH = 8;

  logic        clk = 0, rst_n = 0;
  logic        hp_wr = 0;
  logic [2:0]  hp_ch = 0;
  logic [31:0] hp_addr = 0;
  logic        host_we = 0;
  logic [10:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        dma_req, dma_sop, dma_eop, irq_valid;
  logic        dma_ack = 0;
  logic [2:0]  dma_ch, irq_ch;
  logic [31:0] dma_addr;
  logic [15:0] dma_len;
  logic [7:0]  ch_active, ch_err;

  desc_chain_walker uut (.*);

  always #(PERIOD/2) clk = ~clk;

  int nchk = 0, nbad = 0;
  bit done = 0;
  int ack_max = 2;
  bit hold = 0;

  logic [31:0] e_addr [NCH][16];
  logic [15:0] e_len  [NCH][16];
  logic        e_sop  [NCH][16];
  logic        e_eop  [NCH][16];
  logic [31:0] e_da   [NCH][16];
  logic [31:0] e_st   [NCH][16];
  int e_n[NCH], got[NCH], pk[NCH], irqc[NCH];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // expected write-back: ownership bit 29 dropped, bit 28 = end of list
  function automatic logic [31:0] exp_status(input logic [31:0] w3, input logic [31:0] link);
    return {w3[31:30], 1'b0, (link == 32'd0), w3[27:0]};
  endfunction

  task automatic clear_exp();
    for (int c = 0; c < NCH; c++) begin
      e_n[c] = 0; got[c] = 0; pk[c] = 0; irqc[c] = 0;
    end
  endtask

  task automatic hwrite(input int waddr, input logic [31:0] d);
    host_we = 1; host_addr = 11'(waddr); host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic hread(input int waddr, output logic [31:0] d);
    host_addr = 11'(waddr);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic head(input int c, input logic [31:0] a);
    hp_wr = 1; hp_ch = 3'(c); hp_addr = a;
    @(negedge clk);
    hp_wr = 0;
  endtask

  task automatic put_desc(input int c, input logic [31:0] a, input logic [31:0] w0,
                          input logic [31:0] w1, input logic [31:0] w2, input logic [31:0] w3,
                          input bit expect_it);
    hwrite(a/4 + 0, w0); hwrite(a/4 + 1, w1); hwrite(a/4 + 2, w2); hwrite(a/4 + 3, w3);
    if (expect_it) begin
      e_addr[c][e_n[c]] = w1 + {16'd0, w2[31:16]};
      e_len[c][e_n[c]]  = w2[15:0];
      e_sop[c][e_n[c]]  = w3[31];
      e_eop[c][e_n[c]]  = w3[30];
      e_da[c][e_n[c]]   = a;
      e_st[c][e_n[c]]   = exp_status(w3, w0);
      e_n[c]++;
      if (w3[30]) pk[c]++;
    end
  endtask

  task automatic build_chain(input int c, input logic [31:0] base, input int nd, input bit expect_it);
    bit prev_eop = 1;
    for (int k = 0; k < nd; k++) begin
      logic [31:0] w0, w1, w2, w3;
      bit eop;
      eop = (k == nd - 1) || ($urandom % 3 == 0);
      w0 = (k < nd - 1) ? base + 32'((k + 1) * 32) : 32'd0;
      w1 = $urandom;
      w2 = {16'($urandom % 4096), 16'(1 + $urandom % 2000)};
      w3 = {prev_eop, eop, 1'b1, 1'b0, 12'h0, 16'($urandom)};
      put_desc(c, base + 32'(k * 32), w0, w1, w2, w3, expect_it);
      prev_eop = eop;
    end
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 20000; t++) begin
      if (ch_active == 0 && !dma_req) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic verify_chain(input int c);
    logic [31:0] d;
    check(got[c] == e_n[c], $sformatf("R4 ch%0d fragment count", c), got[c], e_n[c]);
    check(irqc[c] == pk[c], $sformatf("R6 ch%0d packet irq count", c), irqc[c], pk[c]);
    check(ch_active[c] == 0, $sformatf("R7 ch%0d idle at list end", c), ch_active[c], 0);
    for (int k = 0; k < e_n[c]; k++) begin
      hread(e_da[c][k]/4 + 3, d);
      check(d == e_st[c][k], $sformatf("R5 ch%0d desc%0d status", c, k), d, e_st[c][k]);
    end
  endtask

  // data mover model
  initial begin
    forever begin
      @(negedge clk);
      if (dma_req) begin
        int c;
        c = int'(dma_ch);
        if (got[c] >= e_n[c]) begin
          check(0, $sformatf("R4 ch%0d unexpected request", c), dma_addr, 0);
        end else begin
          int k;
          k = got[c];
          check(dma_addr == e_addr[c][k], $sformatf("R3 ch%0d f%0d addr", c, k), dma_addr, e_addr[c][k]);
          check(dma_len == e_len[c][k], $sformatf("R3 ch%0d f%0d len", c, k), 32'(dma_len), 32'(e_len[c][k]));
          check(dma_sop == e_sop[c][k] && dma_eop == e_eop[c][k], $sformatf("R3 ch%0d f%0d flags", c, k),
                {dma_sop, dma_eop}, {e_sop[c][k], e_eop[c][k]});
        end
        got[c]++;
        while (hold) @(negedge clk);
        repeat ($urandom % (ack_max + 1)) @(negedge clk);
        dma_ack = 1;
        @(negedge clk);
        dma_ack = 0;
      end
    end
  end

  // interrupt monitor
  initial begin
    forever begin
      @(negedge clk);
      if (irq_valid) irqc[irq_ch]++;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, b_w3;
    void'($urandom(32'd4711));
    clear_exp();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(ch_active == 0, "R1 active after reset", 32'(ch_active), 0);
    check(ch_err == 0, "R1 err after reset", 32'(ch_err), 0);
    check(!dma_req && !irq_valid, "R1 req/irq after reset", {dma_req, irq_valid}, 0);

    // directed: single-descriptor list on ch7, R2 start check
    build_chain(7, 32'h0E40, 1, 1);
    head(7, 32'h0E40);
    check(ch_active[7] == 1, "R2 start sets active", ch_active[7], 1);
    wait_idle();
    verify_chain(7);

    // random rounds over several channels
    for (int r = 0; r < 6; r++) begin
      logic [7:0] mask;
      clear_exp();
      ack_max = r % 4;
      mask = 8'($urandom);
      if (mask == 0) mask = 8'h81;
      for (int c = 0; c < NCH; c++)
        if (mask[c]) build_chain(c, 32'(c * 32'h200 + 32'h40), 1 + $urandom % 6, 1);
      for (int c = 0; c < NCH; c++)
        if (mask[c]) head(c, 32'(c * 32'h200 + 32'h40));
      wait_idle();
      for (int c = 0; c < NCH; c++) if (mask[c]) verify_chain(c);
    end

    // R8 misaligned head
    clear_exp();
    head(1, 32'h0248);
    repeat (8) @(negedge clk);
    check(ch_err[1] == 1 && ch_active[1] == 0, "R8 misaligned head halts", {ch_err[1], ch_active[1]}, 2'b10);
    check(got[1] == 0, "R8 no fetch on bad head", got[1], 0);
    // R8 out of range head
    head(2, 32'h0000_2000);
    repeat (8) @(negedge clk);
    check(ch_err[2] == 1 && ch_active[2] == 0, "R8 out of range head halts", {ch_err[2], ch_active[2]}, 2'b10);
    // R8 error clears on a good head write
    build_chain(1, 32'h0240, 2, 1);
    head(1, 32'h0240);
    check(ch_err[1] == 0, "R8 error cleared by head write", ch_err[1], 0);
    wait_idle();
    verify_chain(1);

    // R8 bad link in the middle of a list
    clear_exp();
    put_desc(4, 32'h1040, 32'h1048, 32'h100, {16'd4, 16'd64}, 32'hE000_0040, 1);
    head(4, 32'h1040);
    wait_idle();
    check(ch_err[4] == 1, "R8 bad link sets error", ch_err[4], 1);
    verify_chain(4);

    // R9 head write of zero
    clear_exp();
    head(3, 32'd0);
    repeat (4) @(negedge clk);
    check(ch_active[3] == 0 && got[3] == 0, "R9 zero head ignored", {ch_active[3], 8'(got[3])}, 0);

    // R9 head write while active
    build_chain(5, 32'h0A40, 3, 1);
    put_desc(5, 32'h1800, 32'd0, 32'h5000, {16'd0, 16'd8}, 32'hE000_0008, 0);
    hold = 1;
    head(5, 32'h0A40);
    for (int t = 0; t < 50 && !dma_req; t++) @(negedge clk);
    head(5, 32'h1800);
    hold = 0;
    wait_idle();
    verify_chain(5);
    hread(32'h1800/4 + 3, d);
    b_w3 = 32'hE000_0008;
    check(d == b_w3, "R9 second list untouched", d, b_w3);

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule